// File: doc/BRIEF.md
# Interrupt Status Mask Controller

This block collects hardware error events into a small bank of sticky status bits and raises one level interrupt line. The interrupt goes high while any status bit is set and its matching mask bit is clear. Software reads and clears status over a simple 32-bit register bus. The mask can be read but not written directly. Software changes it only through two command words. Writing ones to the unmask word clears the selected mask bits. Writing ones to the mask-set word sets them. Every source starts out masked.

The number of sources is a parameter, with a default of one. Each source bit lives at the bit position equal to its index in every word. The bus accepts one request per cycle and returns the response one cycle later. A request is rejected with an error when it is not a full-word access, when it is misaligned, or when it falls outside the map. A rejected request changes no state.

Register offsets: status at 0x00, mask at 0x04, unmask command at 0x08, mask-set command at 0x0C.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is held, and for the first cycles after it is released, status is zero, every mask bit is one, `irq` is low and `rsp_valid` is low.
- R2: An `err_evt[i]` high at a clock edge sets status bit i, whatever the mask holds. A read of offset 0x00 returns the status bits in bits NUM_SRC-1..0.
- R3: A valid write to offset 0x00 clears each status bit whose data bit is 1 and leaves the other bits alone. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: A write to the mask word at offset 0x04 has no effect. A read of 0x04 returns the mask bits.
- R5: A valid write to offset 0x08 clears each mask bit whose data bit is 1. A read of 0x08 returns zero.
- R6: A valid write to offset 0x0C sets each mask bit whose data bit is 1. A read of 0x0C returns zero.
- R7: `irq` is a register. In the cycle after an edge it equals the OR over all i of (status[i] AND NOT mask[i]), taken from the state held before that edge.
- R8: A request with `req_be` not equal to 4'b1111 gets `rsp_err`=1 and `rsp_rdata`=0, and it changes no register.
- R9: A request whose address is misaligned or is not one of 0x00, 0x04, 0x08 or 0x0C gets `rsp_err`=1 and `rsp_rdata`=0, and it changes no register.
- R10: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. Write responses return `rsp_rdata`=0.
- R11: Data bits at index NUM_SRC and above are ignored on writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables; only 4'b1111 is legal |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read data |
| err_evt | input | NUM_SRC | Hardware error event pulses |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with NUM_SRC=4 and ADDR_W=8. Four sources allow checks that each bit of status and mask is cleared and set independently of the others. Bits 4 to 31 are then present in every word but must stay inert, which makes R11 observable. The 8-bit address reaches unmapped offsets beyond 0x0C as well as misaligned ones. Events are injected on the same cycle as status clears, so the rule that a set beats a clear is exercised under random stimulus as well as in a directed case.

// File: rtl/irqsm_pkg.sv
package irqsm_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned BE_W  = BUS_W / 8;

  // word offsets of the four registers
  localparam int unsigned OFS_STATUS  = 'h0;
  localparam int unsigned OFS_MASK    = 'h4;
  localparam int unsigned OFS_UNMASK  = 'h8;
  localparam int unsigned OFS_MASKSET = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_UNMASK,
    SEL_MASKSET
  } reg_sel_e;
endpackage

// File: rtl/irqsm_rst_sync.sv
module irqsm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqsm_decode.sv
module irqsm_decode
  import irqsm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 1
) (
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BE_W-1:0]    req_be,
  input  logic [BUS_W-1:0]   req_wdata,
  output logic               acc_err,
  output reg_sel_e           sel,
  output logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] unmask_vec,
  output logic [NUM_SRC-1:0] maskset_vec
);
  reg_sel_e sel_raw;
  logic     full_word;
  logic     aligned;
  logic     acc_ok;
  logic     wr_ok;
  logic     unused_wdata;

  assign unused_wdata = ^req_wdata;

  always_comb begin
    if      (req_addr == ADDR_W'(OFS_STATUS))  sel_raw = SEL_STATUS;
    else if (req_addr == ADDR_W'(OFS_MASK))    sel_raw = SEL_MASK;
    else if (req_addr == ADDR_W'(OFS_UNMASK))  sel_raw = SEL_UNMASK;
    else if (req_addr == ADDR_W'(OFS_MASKSET)) sel_raw = SEL_MASKSET;
    else                                       sel_raw = SEL_NONE;
  end

  always_comb begin
    full_word = (req_be == {BE_W{1'b1}});
    aligned   = (req_addr[1:0] == 2'b00);
    acc_ok    = req_valid && full_word && aligned && (sel_raw != SEL_NONE);
    acc_err   = req_valid && !acc_ok;
    sel       = acc_ok ? sel_raw : SEL_NONE;
    wr_ok     = acc_ok && req_write;
  end

  always_comb begin
    clr_vec     = (wr_ok && sel == SEL_STATUS)  ? req_wdata[NUM_SRC-1:0] : '0;
    unmask_vec  = (wr_ok && sel == SEL_UNMASK)  ? req_wdata[NUM_SRC-1:0] : '0;
    maskset_vec = (wr_ok && sel == SEL_MASKSET) ? req_wdata[NUM_SRC-1:0] : '0;
  end
endmodule

// File: rtl/irqsm_bits.sv
module irqsm_bits #(
  parameter int unsigned NUM_SRC = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr_vec,
  input  logic [NUM_SRC-1:0] unmask_vec,
  input  logic [NUM_SRC-1:0] maskset_vec,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic st_d, st_en, mk_d, mk_en;

    // an event in the same cycle overrides a clear
    always_comb begin
      st_en = evt[i] || clr_vec[i];
      st_d  = evt[i];
      mk_en = unmask_vec[i] || maskset_vec[i];
      mk_d  = maskset_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
        mask_q[i]   <= 1'b1;
      end else begin
        if (st_en) status_q[i] <= st_d;
        if (mk_en) mask_q[i]   <= mk_d;
      end
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqsm_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 1   // 1..32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [BE_W-1:0]    req_be,
  input  logic [BUS_W-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [BUS_W-1:0]   rsp_rdata,
  input  logic [NUM_SRC-1:0] err_evt,
  output logic               irq
);
  logic               rst_sync_n;
  logic               acc_err;
  reg_sel_e           sel;
  logic [NUM_SRC-1:0] clr_vec, unmask_vec, maskset_vec;
  logic [NUM_SRC-1:0] status_q, mask_q;
  logic [BUS_W-1:0]   rd_d;
  logic               pend_d;
  logic               rsp_valid_q, rsp_err_q, irq_q;
  logic [BUS_W-1:0]   rsp_rdata_q;

  irqsm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqsm_decode #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_dec (
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .acc_err     (acc_err),
    .sel         (sel),
    .clr_vec     (clr_vec),
    .unmask_vec  (unmask_vec),
    .maskset_vec (maskset_vec)
  );

  irqsm_bits #(.NUM_SRC(NUM_SRC)) u_bits (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .evt         (err_evt),
    .clr_vec     (clr_vec),
    .unmask_vec  (unmask_vec),
    .maskset_vec (maskset_vec),
    .status_q    (status_q),
    .mask_q      (mask_q)
  );

  // read data; command words and writes return zero
  always_comb begin
    rd_d = '0;
    if (!req_write) begin
      case (sel)
        SEL_STATUS: rd_d = BUS_W'(status_q);
        SEL_MASK:   rd_d = BUS_W'(mask_q);
        default:    rd_d = '0;
      endcase
    end
    pend_d = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      irq_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid;
      irq_q       <= pend_d;
      if (req_valid) begin
        rsp_err_q   <= acc_err;
        rsp_rdata_q <= rd_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/irqsm_chk.sv
module irqsm_chk #(
  parameter int unsigned NUM_SRC = 1
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               req_valid,
  input logic [3:0]         req_be,
  input logic [NUM_SRC-1:0] err_evt,
  input logic [NUM_SRC-1:0] unmask_vec,
  input logic [NUM_SRC-1:0] maskset_vec,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [31:0]        rsp_rdata,
  input logic               irq
);
  localparam logic [31:0] LOW_MASK = 32'((64'd1 << NUM_SRC) - 64'd1);

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_evt != '0) |=> ((status_q & $past(err_evt)) == $past(err_evt)));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (unmask_vec == '0 && maskset_vec == '0) |=> $stable(mask_q));

  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq == $past(|(status_q & ~mask_q))));

  p_bad_be_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_be != 4'hF) |=> (rsp_err && $stable(mask_q)));

  p_rsp_follow_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (rsp_valid == $past(req_valid)));

  p_hi_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> ((rsp_rdata & ~LOW_MASK) == 32'd0));
endmodule

bind irq_status_ctrl irqsm_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .req_valid   (req_valid),
  .req_be      (req_be),
  .err_evt     (err_evt),
  .unmask_vec  (unmask_vec),
  .maskset_vec (maskset_vec),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .irq         (irq)
);

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam int AW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_write;
  logic [AW-1:0]   req_addr;
  logic [3:0]      req_be;
  logic [31:0]     req_wdata;
  logic            rsp_valid, rsp_err;
  logic [31:0]     rsp_rdata;
  logic [NSRC-1:0] err_evt;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NSRC-1:0] m_st, m_mk;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_ctrl #(.ADDR_W(AW), .NUM_SRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .err_evt(err_evt), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [AW-1:0] a, input logic [3:0] be);
    return (be != 4'hF) || !(a == 8'h0 || a == 8'h4 || a == 8'h8 || a == 8'hC);
  endfunction

  function automatic logic [31:0] exp_rd(input bit wr, input logic [AW-1:0] a, input logic [3:0] be);
    if (is_bad(a, be) || wr) return 32'd0;
    if (a == 8'h0) return 32'(m_st);
    if (a == 8'h4) return 32'(m_mk);
    return 32'd0;
  endfunction

  // called at a falling edge; checks the response at the next falling edge
  task automatic txn(input bit wr, input logic [AW-1:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic [NSRC-1:0] ev);
    logic [31:0] e_rd;
    bit e_err, e_irq;
    string tag;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd; err_evt = ev;
    e_err = is_bad(a, be);
    e_rd  = exp_rd(wr, a, be);
    e_irq = |(m_st & ~m_mk);
    if (e_err)          tag = (be != 4'hF) ? "R8" : "R9";
    else if (a == 8'h0) tag = wr ? "R3" : "R2";
    else if (a == 8'h4) tag = "R4";
    else if (a == 8'h8) tag = "R5";
    else                tag = "R6";
    @(negedge clk);
    chk(rsp_valid === 1'b1, "R10 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_err === e_err, {tag, " rsp_err"}, 32'(rsp_err), 32'(e_err));
    chk(rsp_rdata === e_rd, {tag, " rdata"}, rsp_rdata, e_rd);
    chk((rsp_rdata >> NSRC) == 0, "R11 high bits", rsp_rdata, e_rd);
    chk(irq === e_irq, "R7 irq", 32'(irq), 32'(e_irq));
    if (!e_err && wr) begin
      if (a == 8'h0) m_st = m_st & ~wd[NSRC-1:0];
      if (a == 8'h8) m_mk = m_mk & ~wd[NSRC-1:0];
      if (a == 8'hC) m_mk = m_mk | wd[NSRC-1:0];
    end
    m_st = m_st | ev;
  endtask

  task automatic idle();
    bit e_irq;
    req_valid = 1'b0; err_evt = '0;
    e_irq = |(m_st & ~m_mk);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 idle rsp_valid", 32'(rsp_valid), 32'd0);
    chk(irq === e_irq, "R7 idle irq", 32'(irq), 32'(e_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_addr = '0; req_be = '0; req_wdata = '0; err_evt = '0;
    m_st = '0; m_mk = '1;
    repeat (4) @(negedge clk);
    chk(irq === 1'b0, "R1 irq in reset", 32'(irq), 32'd0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(irq === 1'b0, "R1 irq after reset", 32'(irq), 32'd0);
    txn(0, 8'h0, 4'hF, 0, 0);               // R1 status zero
    txn(0, 8'h4, 4'hF, 0, 0);               // R1 mask all ones
    // R2: event while masked
    txn(0, 8'h0, 4'hF, 0, 4'b0100);
    txn(0, 8'h0, 4'hF, 0, 0);
    idle(); idle();
    // R5: unmask bit 2, irq rises
    txn(1, 8'h8, 4'hF, 32'h4, 0);
    idle(); idle();
    // R4: direct mask write ignored
    txn(1, 8'h4, 4'hF, 32'h0, 0);
    txn(0, 8'h4, 4'hF, 0, 0);
    // R3: clear with simultaneous set keeps bit
    txn(1, 8'h0, 4'hF, 32'h4, 4'b0100);
    txn(0, 8'h0, 4'hF, 0, 0);
    // R3: clear drops irq
    txn(1, 8'h0, 4'hF, 32'hF, 0);
    idle(); idle();
    // R8: partial access, no change
    txn(1, 8'hC, 4'h1, 32'hF, 0);
    txn(1, 8'h0, 4'hC, 32'hF, 0);
    txn(0, 8'h4, 4'hF, 0, 0);
    // R9: unmapped and misaligned
    txn(1, 8'h20, 4'hF, 32'hF, 0);
    txn(1, 8'h0A, 4'hF, 32'hF, 0);
    txn(0, 8'h02, 4'hF, 0, 0);
    // R5/R6 command reads are zero; R11 high bits ignored
    txn(0, 8'h8, 4'hF, 0, 0);
    txn(0, 8'hC, 4'hF, 0, 0);
    txn(1, 8'h8, 4'hF, 32'hFFFF_FFF0, 0);
    txn(0, 8'h4, 4'hF, 0, 0);
    // R6: mask bit 2 again
    txn(1, 8'hC, 4'hF, 32'h4, 4'b0100);
    idle(); idle();
    // random mix
    for (int n = 0; n < 600; n++) begin
      int k;
      logic [AW-1:0] a;
      logic [3:0] be;
      logic [31:0] wd;
      logic [NSRC-1:0] ev;
      k = int'($urandom % 16);
      case (k)
        0, 1, 2: a = 8'h0;
        3, 4:    a = 8'h4;
        5, 6, 7: a = 8'h8;
        8, 9, 10: a = 8'hC;
        11:      a = 8'h10;
        12:      a = 8'h6;
        default: a = 8'(($urandom % 4) * 4);
      endcase
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      wd = (($urandom % 4) == 0) ? $urandom : 32'($urandom % 16);
      ev = (($urandom % 3) == 0) ? NSRC'($urandom) : '0;
      if (($urandom % 5) == 0) idle();
      else txn(1'($urandom), a, be, wd, ev);
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule